// File: doc/BRIEF.md
# Synchronous FIFO with Graded Occupancy Flags

This block is a single-clock first-in first-out buffer for 9-bit words, with a power-of-two depth set by a parameter (2048 words by default). Words enter through a valid/ready write stream and leave through a valid/ready read stream. The read side is first-word fall-through: the oldest stored word is already on `rd_data` whenever `rd_valid` is high.

Next to the streams, the block drives six plain active-low status pins. All six are decoded from one occupancy counter, so a consumer can react before the buffer hits a hard limit. The pins are:
- empty;
- one-or-fewer words;
- a margin flag covering both the low eighth and the high eighth of the depth;
- more-than-half;
- one-short-of-full or fuller;
- full.

Back-pressure follows the usual stream rules. A word moves only on a rising clock edge where both valid and ready are high on that side. The producer must hold `wr_data` steady while `wr_valid` is high and `wr_ready` is low. When the FIFO is full, `wr_ready` is low, so an offered word is not taken: the memory, the pointers and the flags stay as they were. When the FIFO is empty, `rd_valid` is low, so `rd_ready` has no effect. A write and a read accepted in the same cycle leave the occupancy unchanged.

Top module: `graded_fifo`

## Requirements
- R1: While `rst` is high at a rising edge, the FIFO becomes empty. After that edge, `empty_n`, `emptyp1_n` and `edge_n` are 0, `half_n`, `fullm1_n` and `full_n` are 1, `rd_valid` is 0 and `wr_ready` is 1.
- R2: Words leave in the order they were accepted. Whenever `rd_valid` is 1, `rd_data` shows the oldest stored word.
- R3: `wr_ready` is 1 exactly when occupancy is below DEPTH. A word offered while full is dropped and never appears on `rd_data`.
- R4: `rd_valid` is 1 exactly when occupancy is above 0. `rd_ready` while empty changes no pin and no stored state.
- R5: A cycle that accepts both a write and a read leaves the occupancy, and so all six flags, unchanged.
- R6: `empty_n` is 0 exactly when occupancy is 0. It is released only by an accepted write.
- R7: `emptyp1_n` is 0 exactly when occupancy is 0 or 1.
- R8: `edge_n` is 0 exactly when occupancy is at most DEPTH/8-1, or at least DEPTH-DEPTH/8+1. For DEPTH 2048 these ranges are 0..255 and 1793..2048.
- R9: `half_n` is 0 exactly when occupancy is greater than DEPTH/2. When occupancy is in DEPTH/8..DEPTH/2, all six flags are 1.
- R10: `fullm1_n` is 0 exactly when occupancy is at least DEPTH-1.
- R11: `full_n` is 0 exactly when occupancy equals DEPTH. It is released only by an accepted read.
- R12: Flags and stream status pins reflect the occupancy after the transfers of a rising edge. They change right after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_ready | output | 1 | FIFO can take a word (not full) |
| wr_data | input | DATA_W | Word to store |
| rd_valid | output | 1 | `rd_data` holds a stored word (not empty) |
| rd_ready | input | 1 | Consumer takes `rd_data` |
| rd_data | output | DATA_W | Oldest stored word |
| full_n | output | 1 | Low when occupancy = DEPTH |
| fullm1_n | output | 1 | Low when occupancy >= DEPTH-1 |
| edge_n | output | 1 | Low in the bottom or top eighth margin |
| half_n | output | 1 | Low when occupancy > DEPTH/2 |
| emptyp1_n | output | 1 | Low when occupancy <= 1 |
| empty_n | output | 1 | Low when occupancy = 0 |

## Verification
The bench first runs a pure fill to full followed by a pure drain. This walks the occupancy through every threshold in both directions and shows whether each flag boundary sits one word off. Writes offered at full and reads requested at empty then show whether a blocked transfer leaks into the pointers or the data. A simultaneous read and write at occupancy 1 tells a balanced count apart from one that counts only one side. Random phases weighted toward writing, toward reading and toward balance keep the occupancy hovering around each threshold, which separates correct ordering and flag decode from errors that appear only under mixed traffic.

// File: rtl/gf_pkg.sv
package gf_pkg;

  // Six active-low occupancy indicators, packed for one-bus routing.
  typedef struct packed {
    logic full_n;
    logic fullm1_n;
    logic edge_n;
    logic half_n;
    logic emptyp1_n;
    logic empty_n;
  } occ_flags_t;

  localparam occ_flags_t FLAGS_AT_RESET = '{
    full_n:    1'b1,
    fullm1_n:  1'b1,
    edge_n:    1'b0,
    half_n:    1'b1,
    emptyp1_n: 1'b0,
    empty_n:   1'b0
  };

endpackage

// File: rtl/gf_ptr.sv
module gf_ptr #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr
);

  // Power-of-two depth lets the pointer wrap by plain overflow.
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (step) begin
      ptr <= ptr + 1'b1;
    end
  end

endmodule

// File: rtl/gf_store.sv
module gf_store #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2048,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Asynchronous read gives first-word fall-through at the read port.
  assign rdata = mem[raddr];

endmodule

// File: rtl/gf_occ.sv
module gf_occ #(
  parameter int DEPTH = 2048,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/gf_flag_dec.sv
module gf_flag_dec
  import gf_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic [CNT_W-1:0] count,
  output occ_flags_t       flags
);

  localparam int EIGHTH = DEPTH / 8;
  localparam logic [CNT_W-1:0] LOW_MARGIN_TOP  = CNT_W'(EIGHTH - 1);
  localparam logic [CNT_W-1:0] HIGH_MARGIN_BOT = CNT_W'(DEPTH - EIGHTH + 1);
  localparam logic [CNT_W-1:0] HALF_MARK       = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] NEAR_FULL       = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] ALL_FULL        = CNT_W'(DEPTH);

  always_comb begin
    flags.empty_n   = (count != '0);
    flags.emptyp1_n = (count > CNT_W'(1));
    flags.edge_n    = !((count <= LOW_MARGIN_TOP) || (count >= HIGH_MARGIN_BOT));
    flags.half_n    = !(count > HALF_MARK);
    flags.fullm1_n  = !(count >= NEAR_FULL);
    flags.full_n    = (count != ALL_FULL);
  end

endmodule

// File: rtl/graded_fifo.sv
module graded_fifo
  import gf_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              full_n,
  output logic              fullm1_n,
  output logic              edge_n,
  output logic              half_n,
  output logic              emptyp1_n,
  output logic              empty_n
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = ADDR_W + 1;

  logic [ADDR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0]  count;
  logic              push, pop;
  occ_flags_t        flags;

  // Transfers happen only on a valid/ready handshake.
  assign push = wr_valid && wr_ready;
  assign pop  = rd_valid && rd_ready;

  gf_ptr #(.ADDR_W(ADDR_W)) u_wptr (
    .clk (clk), .rst (rst), .step (push), .ptr (wptr)
  );

  gf_ptr #(.ADDR_W(ADDR_W)) u_rptr (
    .clk (clk), .rst (rst), .step (pop), .ptr (rptr)
  );

  gf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (push),
    .waddr (wptr),
    .wdata (wr_data),
    .raddr (rptr),
    .rdata (rd_data)
  );

  gf_occ #(.DEPTH(DEPTH)) u_occ (
    .clk   (clk),
    .rst   (rst),
    .inc   (push),
    .dec   (pop),
    .count (count)
  );

  gf_flag_dec #(.DEPTH(DEPTH)) u_dec (
    .count (count),
    .flags (flags)
  );

  assign wr_ready  = flags.full_n;
  assign rd_valid  = flags.empty_n;
  assign full_n    = flags.full_n;
  assign fullm1_n  = flags.fullm1_n;
  assign edge_n    = flags.edge_n;
  assign half_n    = flags.half_n;
  assign emptyp1_n = flags.emptyp1_n;
  assign empty_n   = flags.empty_n;

endmodule

// File: rtl/graded_fifo_chk.sv
module graded_fifo_chk (
  input logic clk,
  input logic rst,
  input logic wr_valid,
  input logic wr_ready,
  input logic rd_valid,
  input logic rd_ready,
  input logic full_n,
  input logic fullm1_n,
  input logic edge_n,
  input logic half_n,
  input logic emptyp1_n,
  input logic empty_n
);

  // R1: state right after a reset edge
  a_r1_reset_flags: assert property (@(posedge clk)
    rst |=> (!empty_n && !emptyp1_n && !edge_n && half_n && fullm1_n && full_n));

  // R3: a full FIFO refuses words
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !full_n |-> !wr_ready);

  // R4: an empty FIFO offers nothing
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    !empty_n |-> !rd_valid);

  // R5: balanced transfer holds every flag
  a_r5_balanced_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && rd_valid && rd_ready) |=>
      ($stable(empty_n) && $stable(emptyp1_n) && $stable(edge_n) &&
       $stable(half_n) && $stable(fullm1_n) && $stable(full_n)));

  // R6: empty held until a write is accepted
  a_r6_empty_held: assert property (@(posedge clk) disable iff (rst)
    (!empty_n && !(wr_valid && wr_ready)) |=> !empty_n);

  // R7: empty implies one-or-fewer
  a_r7_nest_low: assert property (@(posedge clk) disable iff (rst)
    !empty_n |-> !emptyp1_n);

  // R8: one-or-fewer lies inside the low margin
  a_r8_low_margin: assert property (@(posedge clk) disable iff (rst)
    !emptyp1_n |-> !edge_n);

  // R10: near-full lies in the top margin and above half
  a_r10_near_full: assert property (@(posedge clk) disable iff (rst)
    !fullm1_n |-> (!edge_n && !half_n));

  // R11: full implies near-full; full held until a read is accepted
  a_r11_nest_high: assert property (@(posedge clk) disable iff (rst)
    !full_n |-> !fullm1_n);

  a_r11_full_held: assert property (@(posedge clk) disable iff (rst)
    (!full_n && !(rd_valid && rd_ready)) |=> !full_n);

endmodule

bind graded_fifo graded_fifo_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .full_n    (full_n),
  .fullm1_n  (fullm1_n),
  .edge_n    (edge_n),
  .half_n    (half_n),
  .emptyp1_n (emptyp1_n),
  .empty_n   (empty_n)
);

// File: tb/test_graded_fifo.sv
module test_graded_fifo;

  localparam int DW = 9;
  localparam int D  = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic          rd_valid;
  logic          rd_ready = 1'b0;
  logic [DW-1:0] rd_data;
  logic          full_n, fullm1_n, edge_n, half_n, emptyp1_n, empty_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int mcount = 0;
  logic [DW-1:0] q[$];

  always #2.5 clk = ~clk;  // 200 MHz

  graded_fifo #(.DATA_W(DW), .DEPTH(D)) i_graded_fifo (
    .clk (clk), .rst (rst),
    .wr_valid (wr_valid), .wr_ready (wr_ready), .wr_data (wr_data),
    .rd_valid (rd_valid), .rd_ready (rd_ready), .rd_data (rd_data),
    .full_n (full_n), .fullm1_n (fullm1_n), .edge_n (edge_n),
    .half_n (half_n), .emptyp1_n (emptyp1_n), .empty_n (empty_n)
  );

  function automatic bit f_empty(int c);  return c == 0; endfunction
  function automatic bit f_ep1(int c);    return c <= 1; endfunction
  function automatic bit f_edge(int c);   return (c <= D/8 - 1) || (c >= D - D/8 + 1); endfunction
  function automatic bit f_half(int c);   return c > D/2; endfunction
  function automatic bit f_fm1(int c);    return c >= D - 1; endfunction
  function automatic bit f_full(int c);   return c == D; endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (occupancy %0d, t=%0t)",
               tag, act, exp, mcount, $time);
    end
  endtask

  task automatic check_all();
    check("R3 wr_ready",  int'(wr_ready),  int'(mcount < D));
    check("R4 rd_valid",  int'(rd_valid),  int'(mcount > 0));
    if (mcount > 0) check("R2 rd_data order", int'(rd_data), int'(q[0]));
    check("R6 empty_n",   int'(empty_n),   int'(!f_empty(mcount)));
    check("R7 emptyp1_n", int'(emptyp1_n), int'(!f_ep1(mcount)));
    check("R8 edge_n",    int'(edge_n),    int'(!f_edge(mcount)));
    check("R9 half_n",    int'(half_n),    int'(!f_half(mcount)));
    check("R10 fullm1_n", int'(fullm1_n),  int'(!f_fm1(mcount)));
    check("R11 full_n",   int'(full_n),    int'(!f_full(mcount)));
  endtask

  // Drive one cycle's inputs after a falling edge, predict, check at next falling edge.
  task automatic cycle(input bit wv, input logic [DW-1:0] wd, input bit rr);
    bit aw, ar;
    wr_valid = wv;
    wr_data  = wd;
    rd_ready = rr;
    aw = wv && (mcount < D);
    ar = rr && (mcount > 0);
    @(negedge clk);
    if (ar) begin void'(q.pop_front()); mcount--; end
    if (aw) begin q.push_back(wd); mcount++; end
    check_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 empty_n",   int'(empty_n),   0);
    check("R1 emptyp1_n", int'(emptyp1_n), 0);
    check("R1 edge_n",    int'(edge_n),    0);
    check("R1 half_n",    int'(half_n),    1);
    check("R1 fullm1_n",  int'(fullm1_n),  1);
    check("R1 full_n",    int'(full_n),    1);
    check("R1 rd_valid",  int'(rd_valid),  0);
    check("R1 wr_ready",  int'(wr_ready),  1);

    // R4: reads at empty change nothing
    for (int i = 0; i < 3; i++) cycle(1'b0, '0, 1'b1);

    // R12: one write releases empty right after its edge
    cycle(1'b1, 9'h0A5, 1'b0);
    check("R12 empty_n after one write", int'(empty_n), 1);

    // R5: balanced transfer at occupancy 1 keeps one word
    cycle(1'b1, 9'h15A, 1'b1);
    check("R5 emptyp1_n held", int'(emptyp1_n), 0);
    check("R5 empty_n held",   int'(empty_n),   1);
    check("R5 rd_data newer word", int'(rd_data), 9'h15A);

    // Fill to full through every threshold
    while (mcount < D) cycle(1'b1, 9'($urandom), 1'b0);
    // R3: offered words at full are dropped
    for (int i = 0; i < 4; i++) cycle(1'b1, 9'h1FF, 1'b0);
    check("R3 full_n still low", int'(full_n), 0);
    // R11: one read releases full
    cycle(1'b0, '0, 1'b1);
    check("R11 full_n after read", int'(full_n), 1);
    // Drain; dropped words must never appear
    while (mcount > 0) cycle(1'b0, '0, 1'b1);
    for (int i = 0; i < 2; i++) cycle(1'b0, '0, 1'b1);

    // Random phases: write-heavy, read-heavy, balanced
    for (int ph = 0; ph < 3; ph++) begin
      int wp, rp;
      wp = (ph == 0) ? 75 : (ph == 1) ? 30 : 55;
      rp = (ph == 0) ? 30 : (ph == 1) ? 75 : 55;
      for (int i = 0; i < 1500; i++)
        cycle(($urandom % 100) < wp, 9'($urandom), ($urandom % 100) < rp);
    end

    // Mid-range reset returns R1 state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    q.delete();
    mcount = 0;
    check("R1 empty_n after mid reset", int'(empty_n), 0);
    check_all();

    finish_run();
  end

endmodule